// File: doc/BRIEF.md
# BCD Time-of-Day Register File

This block holds the timekeeping registers of a real-time clock: a control byte, seconds, minutes, hours, weekday, date, month and year. All time fields are kept in packed BCD. A one-cycle pulse on a seconds-tick input advances a BCD calendar. The calendar carries through minutes, hours, days, months and years, applies the correct month lengths, and can optionally recognise leap years.

Software reaches the registers through a byte-wide port. A read is combinational from the address and returns the live time. A write is taken on the clock edge and loads the addressed field, but only when the value is a well-formed BCD number inside that field's range. Any other write is dropped without trace. A stop flag, kept in the top bit of the seconds register, freezes the calendar. A read-only flags byte from the surrounding logic is visible at one address.

Top module: `tod_regfile`

## Requirements
- R1: After reset the registers read: control (address 2) 0x90, seconds (3) 0x00, minutes (4) 0x00, hours (5) 0x00, weekday (6) 0x01, date (7) 0x01, month (8) 0x01, year (9) 0x00.
- R2: Each `sec_tick` pulse with the stop flag clear advances the time by one second in BCD, one clock edge later. Seconds 59 wraps to 00 and carries into minutes. Minutes 59 carries into hours. Hours 23 wraps to 00 and starts a new day. A new day also advances the weekday, which wraps from 7 to 1. December 31 rolls to January 1 of the next year, and year 99 wraps to 00.
- R3: A day ends after the month's last date: 30 for months 04, 06, 09 and 11; 31 for the other months except February; 29 for February when LEAP_EN is set and the year value is divisible by 4; 28 for February otherwise.
- R4: A write to seconds (3) or minutes (4) loads the low 7 bits, and a write to hours (5) loads the low 6 bits. Each load happens only if both BCD digits are 0-9 and the value is within 00-59 for seconds and minutes, or within 00-23 for hours. Otherwise the time is unchanged.
- R5: A write to date (7) loads the low 5 bits only if they form valid BCD that is nonzero. A write to month (8) loads the low 5 bits only if they form valid BCD in 01-12. A write to year (9) loads all 8 bits only if they form valid BCD in 00-99. Any other write leaves the field unchanged.
- R6: Every write to seconds stores wdata bit 7 as the stop flag, whether or not the seconds value is accepted. While the stop flag is set, ticks have no effect. A seconds read returns the stop flag in bit 7 over the BCD seconds. After the flag is cleared, counting resumes from the held value.
- R7: A write to control (2) stores the written byte with bits 7 and 5 cleared, then bits 7 and 4 set.
- R8: A write to weekday (6) loads bits 2:0 as the weekday and keeps bit 6 as a century flag. A read returns the century flag in bit 6 and the weekday in bits 2:0, with zeros elsewhere. The century flag is untouched by day rollover.
- R9: Address 0 always reads `flags_in`, and writes there have no effect. Address 1 and every address above 9 read 0x00, and writes to them change nothing.
- R10: A tick in the same cycle as an accepted write to any time field (addresses 3 through 9) is discarded, so the written value is what reads back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle pulse, one per second |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| flags_in | input | 8 | Externally driven flags byte shown at address 0 |
| rdata | output | 8 | Combinational read data for `addr` |

## Verification
The counter is driven in three ways. Single ticks from mid-range values confirm plain BCD increments. Ticks from 23:59:59 cascade through every field. Repeated day steps from a written date to each kind of month end separate the 28-, 29-, 30- and 31-day cases and the year wrap. The validation logic is exercised with writes that are too large, writes with a non-decimal digit, and writes with high bits that must be masked off. Together these distinguish range checks from digit checks and from field masking. Ticks are also applied while the stop flag is set, and in the same cycle as a write. These show whether the freeze and the write-priority rule act independently of the load path.

// File: rtl/tod_pkg.sv
package tod_pkg;

   localparam logic [3:0] AD_FLAGS = 4'd0;
   localparam logic [3:0] AD_SPARE = 4'd1;
   localparam logic [3:0] AD_CTRL  = 4'd2;
   localparam logic [3:0] AD_SEC   = 4'd3;
   localparam logic [3:0] AD_MIN   = 4'd4;
   localparam logic [3:0] AD_HOUR  = 4'd5;
   localparam logic [3:0] AD_WDAY  = 4'd6;
   localparam logic [3:0] AD_DATE  = 4'd7;
   localparam logic [3:0] AD_MONTH = 4'd8;
   localparam logic [3:0] AD_YEAR  = 4'd9;

   typedef struct packed {
      logic [6:0] sec;
      logic [6:0] min;
      logic [5:0] hour;
      logic [2:0] wday;
      logic [5:0] date;
      logic [4:0] month;
      logic [7:0] year;
   } tod_time_t;

   typedef struct packed {
      logic sec;
      logic min;
      logic hour;
      logic wday;
      logic date;
      logic month;
      logic year;
   } tod_load_t;

   // both digits decimal and value not above limit (BCD order matches numeric order)
   function automatic logic bcd_ok(input logic [7:0] v, input logic [7:0] lim);
      return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9) && (v <= lim);
   endfunction

   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
      else                return v + 8'd1;
   endfunction

endpackage

// File: rtl/tod_wr_check.sv
module tod_wr_check
   import tod_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output tod_load_t         ld,
   output logic              stop_we,
   output logic              ctrl_we
);
   logic       hit;
   logic [3:0] sel;
   logic [7:0] v5;

   assign hit = wr_en && ((addr >> 4) == '0);
   assign sel = addr[3:0];
   assign v5  = {3'b000, wdata[4:0]};

   always_comb begin
      ld      = '0;
      stop_we = 1'b0;
      ctrl_we = 1'b0;
      if (hit) begin
         unique case (sel)
            AD_CTRL:  ctrl_we  = 1'b1;
            AD_SEC: begin
               stop_we = 1'b1;
               ld.sec  = bcd_ok({1'b0, wdata[6:0]}, 8'h59);
            end
            AD_MIN:   ld.min   = bcd_ok({1'b0, wdata[6:0]}, 8'h59);
            AD_HOUR:  ld.hour  = bcd_ok({2'b00, wdata[5:0]}, 8'h23);
            AD_WDAY:  ld.wday  = 1'b1;
            AD_DATE:  ld.date  = bcd_ok(v5, 8'h19) && (v5 != 8'h00);
            AD_MONTH: ld.month = bcd_ok(v5, 8'h12) && (v5 != 8'h00);
            AD_YEAR:  ld.year  = bcd_ok(wdata, 8'h99);
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/tod_calendar.sv
module tod_calendar
   import tod_pkg::*;
#(
   parameter bit LEAP_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_en,
   input  tod_load_t  ld,
   input  logic [7:0] wdata,
   output tod_time_t  now
);
   tod_time_t  nxt;
   logic       is_leap;
   logic [5:0] last_day;
   logic [7:0] yr_bin;

   assign yr_bin = ({4'd0, now.year[7:4]} * 8'd10) + {4'd0, now.year[3:0]};

   generate
      if (LEAP_EN) begin : g_leap
         assign is_leap = (yr_bin[1:0] == 2'b00);
      end else begin : g_noleap
         assign is_leap = 1'b0;
      end
   endgenerate

   always_comb begin
      unique case (now.month)
         5'h02:                      last_day = is_leap ? 6'h29 : 6'h28;
         5'h04, 5'h06, 5'h09, 5'h11: last_day = 6'h30;
         default:                    last_day = 6'h31;
      endcase
   end

   always_comb begin
      nxt = now;
      if (ld.sec)        nxt.sec   = wdata[6:0];
      else if (ld.min)   nxt.min   = wdata[6:0];
      else if (ld.hour)  nxt.hour  = wdata[5:0];
      else if (ld.wday)  nxt.wday  = wdata[2:0];
      else if (ld.date)  nxt.date  = {1'b0, wdata[4:0]};
      else if (ld.month) nxt.month = wdata[4:0];
      else if (ld.year)  nxt.year  = wdata;
      else if (tick_en) begin
         if (now.sec != 7'h59) nxt.sec = 7'(bcd_inc({1'b0, now.sec}));
         else begin
            nxt.sec = '0;
            if (now.min != 7'h59) nxt.min = 7'(bcd_inc({1'b0, now.min}));
            else begin
               nxt.min = '0;
               if (now.hour != 6'h23) nxt.hour = 6'(bcd_inc({2'b00, now.hour}));
               else begin
                  nxt.hour = '0;
                  nxt.wday = (now.wday == 3'd7) ? 3'd1 : now.wday + 3'd1;
                  if (now.date != last_day) nxt.date = 6'(bcd_inc({2'b00, now.date}));
                  else begin
                     nxt.date = 6'h01;
                     if (now.month != 5'h12) nxt.month = 5'(bcd_inc({3'b000, now.month}));
                     else begin
                        nxt.month = 5'h01;
                        nxt.year  = (now.year == 8'h99) ? 8'h00 : bcd_inc(now.year);
                     end
                  end
               end
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         now <= '{sec: 7'h00, min: 7'h00, hour: 6'h00, wday: 3'd1,
                  date: 6'h01, month: 5'h01, year: 8'h00};
      end else begin
         now <= nxt;
      end
   end
endmodule

// File: rtl/tod_rd_mux.sv
module tod_rd_mux
   import tod_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input  logic [ADDR_W-1:0] addr,
   input  tod_time_t         now,
   input  logic              stop_q,
   input  logic              cent_q,
   input  logic [7:0]        ctrl_q,
   input  logic [7:0]        flags_in,
   output logic [7:0]        rdata
);
   always_comb begin
      rdata = 8'h00;
      if ((addr >> 4) == '0) begin
         unique case (addr[3:0])
            AD_FLAGS: rdata = flags_in;
            AD_CTRL:  rdata = ctrl_q;
            AD_SEC:   rdata = {stop_q, now.sec};
            AD_MIN:   rdata = {1'b0, now.min};
            AD_HOUR:  rdata = {2'b00, now.hour};
            AD_WDAY:  rdata = {1'b0, cent_q, 3'b000, now.wday};
            AD_DATE:  rdata = {2'b00, now.date};
            AD_MONTH: rdata = {3'b000, now.month};
            AD_YEAR:  rdata = now.year;
            default:  rdata = 8'h00;
         endcase
      end
   end
endmodule

// File: rtl/tod_regfile.sv
module tod_regfile
   import tod_pkg::*;
#(
   parameter int ADDR_W  = 4,
   parameter bit LEAP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   input  logic [7:0]        flags_in,
   output logic [7:0]        rdata
);
   localparam logic [7:0] CTRL_CLR = 8'hA0;
   localparam logic [7:0] CTRL_SET = 8'h90;

   generate
      if (ADDR_W < 4) begin : g_bad_addr_w
         $error("tod_regfile: ADDR_W must be at least 4");
      end
   endgenerate

   tod_load_t  ld;
   tod_time_t  now_q;
   logic       stop_we, ctrl_we, tick_en;
   logic       stop_q, cent_q;
   logic [7:0] ctrl_q;

   tod_wr_check #(.ADDR_W(ADDR_W)) u_wchk (
      .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .ld(ld), .stop_we(stop_we), .ctrl_we(ctrl_we)
   );

   // an accepted time write takes priority over a coincident tick
   assign tick_en = sec_tick && !stop_q && (ld == '0);

   tod_calendar #(.LEAP_EN(LEAP_EN)) u_cal (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .ld(ld), .wdata(wdata), .now(now_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stop_q <= 1'b0;
         cent_q <= 1'b0;
         ctrl_q <= CTRL_SET;
      end else begin
         if (stop_we) stop_q <= wdata[7];
         if (ld.wday) cent_q <= wdata[6];
         if (ctrl_we) ctrl_q <= (wdata & ~CTRL_CLR) | CTRL_SET;
      end
   end

   tod_rd_mux #(.ADDR_W(ADDR_W)) u_rd (
      .addr(addr), .now(now_q), .stop_q(stop_q), .cent_q(cent_q),
      .ctrl_q(ctrl_q), .flags_in(flags_in), .rdata(rdata)
   );
endmodule

// File: rtl/tod_regfile_chk.sv
module tod_regfile_chk
   import tod_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sec_tick,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [7:0]        wdata,
   input logic [7:0]        flags_in,
   input logic [7:0]        rdata,
   input logic              stop_q,
   input logic [7:0]        ctrl_q,
   input tod_time_t         now_q
);
   a_r9_flags_visible: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == ADDR_W'(AD_FLAGS)) |-> (rdata == flags_in));

   a_r6_stop_freezes: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_q && !wr_en) |=> $stable(now_q));

   a_r2_sec_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && !stop_q && !wr_en && now_q.sec[3:0] != 4'd9)
      |=> (now_q.sec == $past(now_q.sec) + 7'd1));

   a_r2_sec_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (now_q.sec[3:0] <= 4'd9) && (now_q.sec <= 7'h59));

   a_r3_date_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      (now_q.date != 6'h00) && (now_q.date <= 6'h31));

   a_r7_ctrl_forced: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[7] && ctrl_q[4] && !ctrl_q[5]);

   a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(AD_MIN) && wdata[6:4] <= 3'd5 && wdata[3:0] <= 4'd9)
      |=> (now_q.min == $past(wdata[6:0])) && $stable(now_q.sec));
endmodule

bind tod_regfile tod_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wr_en(wr_en),
   .addr(addr), .wdata(wdata), .flags_in(flags_in), .rdata(rdata),
   .stop_q(stop_q), .ctrl_q(ctrl_q), .now_q(now_q)
);

// File: tb/sim_tod_regfile.sv
module sim_tod_regfile;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              sec_tick = 1'b0;
   logic              wr_en = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [7:0]        wdata = '0;
   logic [7:0]        flags_in = 8'h5A;
   logic [7:0]        rdata;

   int n_chk = 0;
   int n_err = 0;

   tod_regfile #(.ADDR_W(ADDR_W), .LEAP_EN(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .flags_in(flags_in), .rdata(rdata)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   initial begin
      #(CLK_PERIOD * 200000);
      n_err++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic tk = 1'b0);
      @(negedge clk);
      addr = ADDR_W'(a); wdata = d; wr_en = 1'b1; sec_tick = tk;
      @(negedge clk);
      wr_en = 1'b0; sec_tick = 1'b0;
   endtask

   task automatic tick();
      @(negedge clk);
      sec_tick = 1'b1;
      @(negedge clk);
      sec_tick = 1'b0;
   endtask

   task automatic expect_rd(input string tag, input logic [3:0] a, input logic [7:0] exp);
      addr = ADDR_W'(a);
      #1;
      n_chk++;
      if (rdata !== exp) begin
         n_err++;
         $display("FAIL %s addr=%0d actual=%02h expected=%02h", tag, a, rdata, exp);
      end
   endtask

   task automatic next_day();
      wr(4'd3, 8'h59);
      wr(4'd4, 8'h59);
      wr(4'd5, 8'h23);
      tick();
   endtask

   task automatic t_reset();
      expect_rd("R1 ctrl",  4'd2, 8'h90);
      expect_rd("R1 sec",   4'd3, 8'h00);
      expect_rd("R1 min",   4'd4, 8'h00);
      expect_rd("R1 hour",  4'd5, 8'h00);
      expect_rd("R1 wday",  4'd6, 8'h01);
      expect_rd("R1 date",  4'd7, 8'h01);
      expect_rd("R1 month", 4'd8, 8'h01);
      expect_rd("R1 year",  4'd9, 8'h00);
   endtask

   task automatic t_tick_cascade();
      tick();
      expect_rd("R2 first tick", 4'd3, 8'h01);
      wr(4'd3, 8'h09); tick();
      expect_rd("R2 digit carry", 4'd3, 8'h10);
      wr(4'd6, 8'h47); wr(4'd7, 8'h05);
      next_day();
      expect_rd("R2 sec wrap",  4'd3, 8'h00);
      expect_rd("R2 min wrap",  4'd4, 8'h00);
      expect_rd("R2 hour wrap", 4'd5, 8'h00);
      expect_rd("R2 date step", 4'd7, 8'h06);
      expect_rd("R2 R8 weekday 7->1 keeps century", 4'd6, 8'h41);
   endtask

   task automatic t_month_ends();
      // January: 31 days
      wr(4'd9, 8'h23); wr(4'd8, 8'h01); wr(4'd7, 8'h19);
      for (int i = 0; i < 12; i++) next_day();
      expect_rd("R3 jan 31", 4'd7, 8'h31);
      next_day();
      expect_rd("R3 jan->feb date", 4'd7, 8'h01);
      expect_rd("R3 jan->feb month", 4'd8, 8'h02);
      // February in a non-leap year
      wr(4'd7, 8'h19);
      for (int i = 0; i < 9; i++) next_day();
      expect_rd("R3 feb 28", 4'd7, 8'h28);
      next_day();
      expect_rd("R3 feb(23) -> mar", 4'd8, 8'h03);
      // February in a leap year
      wr(4'd9, 8'h24); wr(4'd8, 8'h02); wr(4'd7, 8'h19);
      for (int i = 0; i < 10; i++) next_day();
      expect_rd("R3 leap feb 29", 4'd7, 8'h29);
      next_day();
      expect_rd("R3 leap feb->mar month", 4'd8, 8'h03);
      expect_rd("R3 leap feb->mar date", 4'd7, 8'h01);
      // April: 30 days
      wr(4'd8, 8'h04); wr(4'd7, 8'h19);
      for (int i = 0; i < 11; i++) next_day();
      expect_rd("R3 apr 30", 4'd7, 8'h30);
      next_day();
      expect_rd("R3 apr->may", 4'd8, 8'h05);
      // year end and century wrap of the year field
      wr(4'd9, 8'h99); wr(4'd8, 8'h12); wr(4'd7, 8'h19);
      for (int i = 0; i < 12; i++) next_day();
      expect_rd("R2 dec 31", 4'd7, 8'h31);
      next_day();
      expect_rd("R2 new year month", 4'd8, 8'h01);
      expect_rd("R2 new year date", 4'd7, 8'h01);
      expect_rd("R2 year 99->00", 4'd9, 8'h00);
   endtask

   task automatic t_validation();
      wr(4'd3, 8'h30); wr(4'd4, 8'h15); wr(4'd5, 8'h12);
      wr(4'd7, 8'h07); wr(4'd8, 8'h06); wr(4'd9, 8'h42);
      wr(4'd3, 8'h60); expect_rd("R4 sec 60 dropped", 4'd3, 8'h30);
      wr(4'd3, 8'h4A); expect_rd("R4 sec nondigit dropped", 4'd3, 8'h30);
      wr(4'd4, 8'h7F); expect_rd("R4 min 7F dropped", 4'd4, 8'h15);
      wr(4'd5, 8'h24); expect_rd("R4 hour 24 dropped", 4'd5, 8'h12);
      wr(4'd5, 8'h1A); expect_rd("R4 hour nondigit dropped", 4'd5, 8'h12);
      wr(4'd5, 8'hC5); expect_rd("R4 hour high bits masked", 4'd5, 8'h05);
      wr(4'd7, 8'h00); expect_rd("R5 date 0 dropped", 4'd7, 8'h07);
      wr(4'd7, 8'h0A); expect_rd("R5 date nondigit dropped", 4'd7, 8'h07);
      wr(4'd7, 8'hE3); expect_rd("R5 date masked to 5 bits", 4'd7, 8'h03);
      wr(4'd8, 8'h13); expect_rd("R5 month 13 dropped", 4'd8, 8'h06);
      wr(4'd8, 8'h00); expect_rd("R5 month 0 dropped", 4'd8, 8'h06);
      wr(4'd9, 8'h9A); expect_rd("R5 year nondigit dropped", 4'd9, 8'h42);
      wr(4'd9, 8'hA0); expect_rd("R5 year A0 dropped", 4'd9, 8'h42);
      wr(4'd9, 8'h99); expect_rd("R5 year 99 loads", 4'd9, 8'h99);
   endtask

   task automatic t_stop();
      wr(4'd3, 8'h85);
      expect_rd("R6 stop read", 4'd3, 8'h85);
      tick(); tick();
      expect_rd("R6 frozen", 4'd3, 8'h85);
      wr(4'd3, 8'h7A);
      expect_rd("R6 stop cleared value kept", 4'd3, 8'h05);
      tick();
      expect_rd("R6 resumes", 4'd3, 8'h06);
   endtask

   task automatic t_ctrl_wday();
      wr(4'd2, 8'hFF); expect_rd("R7 ctrl FF", 4'd2, 8'hDF);
      wr(4'd2, 8'h00); expect_rd("R7 ctrl 00", 4'd2, 8'h90);
      wr(4'd2, 8'h2A); expect_rd("R7 ctrl 2A", 4'd2, 8'h9A);
      wr(4'd6, 8'hC5); expect_rd("R8 century and weekday", 4'd6, 8'h45);
      wr(4'd6, 8'h3B); expect_rd("R8 century cleared", 4'd6, 8'h03);
   endtask

   task automatic t_flags_unused();
      expect_rd("R9 flags", 4'd0, 8'h5A);
      wr(4'd0, 8'hFF); expect_rd("R9 flags write ignored", 4'd0, 8'h5A);
      flags_in = 8'hA5; expect_rd("R9 flags follow input", 4'd0, 8'hA5);
      wr(4'd1, 8'h77); expect_rd("R9 spare reads zero", 4'd1, 8'h00);
      wr(4'd15, 8'h33); expect_rd("R9 high address zero", 4'd15, 8'h00);
      expect_rd("R9 no side effect on sec", 4'd3, 8'h06);
   endtask

   task automatic t_collision();
      wr(4'd3, 8'h20);
      wr(4'd4, 8'h30, 1'b1);
      expect_rd("R10 min written", 4'd4, 8'h30);
      expect_rd("R10 tick discarded", 4'd3, 8'h20);
      wr(4'd3, 8'h44, 1'b1);
      expect_rd("R10 sec write wins", 4'd3, 8'h44);
      wr(4'd3, 8'h61, 1'b1);
      expect_rd("R10 rejected write lets tick through", 4'd3, 8'h45);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_tick_cascade();
      t_month_ends();
      t_validation();
      t_stop();
      t_ctrl_wday();
      t_flags_unused();
      t_collision();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule